// File: doc/BRIEF.md
# Digital Loss-of-Signal Detector

This block watches a recovered pulse-presence stream, one bit per recovered clock interval (1 means a pulse was seen, 0 means none), and keeps a registered loss-of-signal flag. The flag goes high once the line has been silent for a long, fixed run of intervals. It drops again only after an equally long window of intervals in which no short burst of zeros, called an excessive-zero event, occurs.

The length of zero run that counts as an excessive-zero event depends on a rate-select input. One setting covers the DS3/STS-1 line rates and the other covers the E3 rate. Upstream muting simply presents zeros, so a muted receiver always leads to a loss declaration. A data-valid input qualifies each interval, and invalid cycles leave all state untouched.

Top module: `dlos_detector`

## Requirements
- R1: Reset (synchronous, active high on `rst`) drives `los_o` to 1 and zeroes the zero-run count and the clear-window count. After reset, exactly LOS_COUNT valid ones are needed to drop the flag.
- R2: While `los_o` is 0, the LOS_COUNT-th consecutive valid zero sets `los_o` to 1 on the same clock edge that samples it. LOS_COUNT-1 zeros leave the flag at 0. Muted (zero) input is treated like any other zero.
- R3: A valid one restarts the consecutive-zero count, so a one anywhere in the run delays the declaration.
- R4: While `los_o` is 1, the flag clears on the edge that samples the LOS_COUNT-th consecutive valid interval with no excessive-zero event.
- R5: With `rate_e3` = 0 (DS3/STS-1), an excessive-zero event is the third or later zero of a consecutive run. The repeating pattern 1,0,0 therefore clears the flag, and the pattern 1,0,0,0 does not.
- R6: With `rate_e3` = 1 (E3), an excessive-zero event is the fourth or later zero of a consecutive run. The pattern 1,0,0,0 clears the flag, and the pattern 1,0,0,0,0 does not.
- R7: While `los_o` is 1, an excessive-zero event restarts the clear window from zero.
- R8: A cycle with `bit_valid` = 0 leaves both counts and the flag unchanged, whatever `bit_in` holds.
- R9: LOS_COUNT is an elaboration-time parameter with default 175. It must lie in 100..250, which also keeps every window inside 10..255 intervals. Elaboration reports an error otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_e3 | input | 1 | 0 = DS3/STS-1 excessive-zero rule, 1 = E3 rule |
| bit_valid | input | 1 | Qualifies `bit_in` for this interval |
| bit_in | input | 1 | Pulse presence (1 = pulse, 0 = no pulse) |
| los_o | output | 1 | Registered loss-of-signal flag |

## Verification
Long all-zero runs that stop one interval short of the limit, or that reach it exactly, separate a correct declaration point from an off-by-one. Runs broken by a single one show that the zero count restarts. Periodic patterns whose zero runs sit just below and just at the excessive-zero length are driven in both rate settings, which distinguishes the two rules. An excessive-zero event placed late in a clear window shows that the window restarts rather than saturating. Invalid cycles carrying ones, placed inside a zero run, show that the state is frozen. Random bursts of long and short zero runs, with mode changes and gaps in validity, are compared interval by interval against a reference model in the bench.

// File: rtl/dlos_pkg.sv
package dlos_pkg;

  typedef enum logic {
    RATE_DS3 = 1'b0,
    RATE_E3  = 1'b1
  } rate_e;

  // zero-run length at which a run becomes an excessive-zero event
  function automatic int unsigned excess_len(rate_e r);
    return (r == RATE_E3) ? 32'd4 : 32'd3;
  endfunction

  // next value of a saturating consecutive-zero counter
  function automatic int unsigned next_run(int unsigned run, logic pulse, int unsigned sat);
    if (pulse) return 0;
    return (run >= sat) ? sat : run + 1;
  endfunction

endpackage

// File: rtl/dlos_zero_run.sv
module dlos_zero_run #(
  parameter int unsigned SAT = 175,
  localparam int unsigned CW = $clog2(SAT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid_i,
  input  logic          bit_i,
  output logic [CW-1:0] run_q,
  output logic [CW-1:0] run_next
);
  import dlos_pkg::*;

  always_comb begin
    if (valid_i) run_next = CW'(next_run(int'(run_q), bit_i, SAT));
    else         run_next = run_q;
  end

  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else     run_q <= run_next;
  end
endmodule

// File: rtl/dlos_clear_window.sv
module dlos_clear_window #(
  parameter int unsigned LIMIT = 175,
  localparam int unsigned CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid_i,
  input  logic          active_i,
  input  logic          restart_i,
  output logic [CW-1:0] win_q,
  output logic          full_ev
);
  assign full_ev = active_i && valid_i && !restart_i && (win_q == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst)                     win_q <= '0;
    else if (valid_i) begin
      if (!active_i || restart_i || full_ev) win_q <= '0;
      else                                   win_q <= win_q + 1'b1;
    end
  end
endmodule

// File: rtl/dlos_flag.sv
module dlos_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst)        flag_q <= 1'b1;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end
endmodule

// File: rtl/dlos_detector.sv
module dlos_detector #(
  parameter int unsigned LOS_COUNT = 175
) (
  input  logic clk,
  input  logic rst,
  input  logic rate_e3,
  input  logic bit_valid,
  input  logic bit_in,
  output logic los_o
);
  import dlos_pkg::*;

  localparam int unsigned CW = $clog2(LOS_COUNT + 1);

  if (LOS_COUNT < 100 || LOS_COUNT > 250) begin : g_bad_count
    $error("dlos_detector: LOS_COUNT out of 100..250");
  end

  logic [CW-1:0] run_q, run_next, win_q;
  logic          zero_bit, excess_ev, declare_ev, clear_ev;
  rate_e         rate;

  assign rate     = rate_e'(rate_e3);
  assign zero_bit = bit_valid && !bit_in;

  dlos_zero_run #(.SAT(LOS_COUNT)) u_run (
    .clk(clk), .rst(rst), .valid_i(bit_valid), .bit_i(bit_in),
    .run_q(run_q), .run_next(run_next)
  );

  assign excess_ev  = zero_bit && (int'(run_next) >= excess_len(rate));
  assign declare_ev = !los_o && zero_bit && (int'(run_next) >= LOS_COUNT);

  dlos_clear_window #(.LIMIT(LOS_COUNT)) u_win (
    .clk(clk), .rst(rst), .valid_i(bit_valid), .active_i(los_o),
    .restart_i(excess_ev), .win_q(win_q), .full_ev(clear_ev)
  );

  dlos_flag u_flag (
    .clk(clk), .rst(rst), .set_i(declare_ev), .clr_i(clear_ev), .flag_q(los_o)
  );
endmodule

// File: rtl/dlos_detector_chk.sv
module dlos_detector_chk #(
  parameter int unsigned LOS_COUNT = 175,
  localparam int unsigned CW = $clog2(LOS_COUNT + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          bit_valid,
  input logic          bit_in,
  input logic          los_o,
  input logic [CW-1:0] run_q,
  input logic [CW-1:0] win_q,
  input logic          excess_ev
);
  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) && !rst |-> los_o && run_q == '0 && win_q == '0);

  p_rise_on_zero_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(los_o) |-> $past(bit_valid) && !$past(bit_in));

  p_one_restarts_r3: assert property (@(posedge clk) disable iff (rst)
    bit_valid && bit_in |=> run_q == '0);

  p_fall_after_window_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(los_o) |-> $past(bit_valid) && $past(win_q) == CW'(LOS_COUNT - 1));

  p_excess_restarts_r7: assert property (@(posedge clk) disable iff (rst)
    los_o && excess_ev |=> win_q == '0);

  p_frozen_when_invalid_r8: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> $stable(los_o) && $stable(run_q) && $stable(win_q));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    run_q <= CW'(LOS_COUNT) && win_q < CW'(LOS_COUNT));
endmodule

bind dlos_detector dlos_detector_chk #(.LOS_COUNT(LOS_COUNT)) u_chk (
  .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
  .los_o(los_o), .run_q(run_q), .win_q(win_q), .excess_ev(excess_ev)
);

// File: tb/dlos_detector_test.sv
module dlos_detector_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 175;

  logic clk = 1'b0;
  logic rst, rate_e3, bit_valid, bit_in;
  logic los_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference state
  bit m_los;
  int m_run, m_win;

  dlos_detector #(.LOS_COUNT(N)) uut (
    .clk(clk), .rst(rst), .rate_e3(rate_e3), .bit_valid(bit_valid),
    .bit_in(bit_in), .los_o(los_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int short_limit(logic e3);
    return e3 ? 4 : 3;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: los_o=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(logic v, logic d);
    int run_n;
    bit ev;
    if (!v) return;
    run_n = d ? 0 : ((m_run < N) ? m_run + 1 : N);
    ev = !d && run_n >= short_limit(rate_e3);
    if (!m_los) begin
      m_win = 0;
      if (!d && run_n >= N) m_los = 1;
    end else if (ev) begin
      m_win = 0;
    end else if (m_win + 1 == N) begin
      m_los = 0;
      m_win = 0;
    end else begin
      m_win++;
    end
    m_run = run_n;
  endtask

  task automatic send(logic v, logic d);
    @(negedge clk);
    bit_valid = v;
    bit_in = d;
    @(posedge clk);
    model_step(v, d);
    #(CLK_PERIOD/4);
    chk("R2 R4 model", los_o, m_los);
  endtask

  task automatic send_n(int n, logic d);
    for (int i = 0; i < n; i++) send(1'b1, d);
  endtask

  task automatic send_pattern(int zeros, int reps);
    for (int r = 0; r < reps; r++) begin
      send(1'b1, 1'b1);
      send_n(zeros, 1'b0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; rate_e3 = 1'b0; bit_valid = 1'b0; bit_in = 1'b0;
    m_los = 1; m_run = 0; m_win = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk("R1 reset flag", los_o, 1'b1);

    // R1 R4: exactly N ones after reset
    send_n(N - 1, 1'b1);
    chk("R1 N-1 ones", los_o, 1'b1);
    send_n(1, 1'b1);
    chk("R4 Nth one clears", los_o, 1'b0);

    // R2: declaration point
    send_n(N - 1, 1'b0);
    chk("R2 N-1 zeros", los_o, 1'b0);
    send_n(1, 1'b0);
    chk("R2 Nth zero", los_o, 1'b1);
    send_n(N, 1'b1);
    chk("R4 clear", los_o, 1'b0);

    // R3: one inside the run restarts it
    send_n(N - 1, 1'b0);
    send_n(1, 1'b1);
    send_n(N - 1, 1'b0);
    chk("R3 restarted run", los_o, 1'b0);
    send_n(1, 1'b0);
    chk("R3 full run after one", los_o, 1'b1);

    // R5: DS3 rule
    rate_e3 = 1'b0;
    send_pattern(2, 59);
    chk("R5 pattern 100 clears", los_o, 1'b0);
    send_n(N, 1'b0);
    send_pattern(3, 60);
    chk("R5 pattern 1000 holds", los_o, 1'b1);

    // R6: E3 rule
    rate_e3 = 1'b1;
    send_pattern(3, 50);
    chk("R6 pattern 1000 clears", los_o, 1'b0);
    send_n(N, 1'b0);
    send_pattern(4, 50);
    chk("R6 pattern 10000 holds", los_o, 1'b1);

    // R7: excessive-zero event restarts the window
    rate_e3 = 1'b0;
    send_n(N - 10, 1'b1);
    send_n(3, 1'b0);
    send_n(N - 1, 1'b1);
    chk("R7 window restarted", los_o, 1'b1);
    send_n(1, 1'b1);
    chk("R7 window completes", los_o, 1'b0);

    // R8: invalid cycles freeze state
    for (int i = 0; i < 300; i++) send(1'b0, 1'b0);
    chk("R8 invalid zeros ignored", los_o, 1'b0);
    send_n(N - 1, 1'b0);
    for (int i = 0; i < 5; i++) send(1'b0, 1'b1);
    chk("R8 invalid ones hold", los_o, 1'b0);
    send_n(1, 1'b0);
    chk("R8 run kept across gap", los_o, 1'b1);
    for (int i = 0; i < 200; i++) send(1'b0, 1'b1);
    chk("R8 flag frozen", los_o, 1'b1);

    // random bursts
    void'($urandom(32'd2024));
    for (int b = 0; b < 120; b++) begin
      int zl, ol;
      if ($urandom_range(0, 7) == 0) rate_e3 = ~rate_e3;
      zl = ($urandom_range(0, 1) == 1) ? $urandom_range(0, 5) : $urandom_range(0, 260);
      ol = $urandom_range(1, 12);
      for (int i = 0; i < zl; i++) send($urandom_range(0, 9) != 0, 1'b0);
      for (int i = 0; i < ol; i++) send($urandom_range(0, 9) != 0, 1'b1);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule